// File: doc/BRIEF.md
# Vector Element Register Buffer

This block is a bank of vector registers built from 64-bit elements. It sits between a scalar core and the path toward the L2 cache. The buffer has no arithmetic of its own. The core moves one element at a time between the buffer and its scalar registers. A block-transfer engine on the memory side fills or drains whole registers as a stream of element writes or reads, one element per beat.

Both sides name an element with a register number and an element index, so they can work at the same time. Two constant outputs report the register length and the register count. Software reads them to size its loops, which lets one program run on builds of any length.

The register length must be a power of two between 16 and 256. The default build has 32 registers of 64 elements each, which is 16 KB of storage.

Top module: `vreg_buffer`

## Requirements
- R1: Every element holds a full 64-bit word, and all 64 bits come back unchanged on either read port. The default build addresses register numbers 0 to 31 and element indices 0 to 63.
- R2: `cfg_vlen` always reports the register length (64 by default). `cfg_nregs` always reports the register count (32 by default).
- R3: A core read with an in-range index returns the addressed element on `core_rdata`, with `core_rvalid` high, in the cycle after the request.
- R4: A core write with an in-range index stores `core_wdata`. A read issued in a later cycle returns that value.
- R5: A core read or write whose 7-bit index is 64 or more raises `core_err` in the next cycle and keeps `core_rvalid` low. Such a write changes no element, including element 0 of the next register number.
- R6: A memory-side write stores `mem_wdata`. A memory-side read returns the addressed element on `mem_rdata`, with `mem_rvalid` high, in the next cycle.
- R7: A memory-side write and a core write to different registers in the same cycle both take effect.
- R8: When a memory-side write and a core write hit the same register and element in one cycle, the memory-side value is the one stored.
- R9: A read in the same cycle as a write to the same element returns the value held before that write.
- R10: While reset is held and in the first cycle after it, `core_rvalid`, `core_err`, `mem_rvalid`, `core_rdata` and `mem_rdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the output registers |
| core_rd_en | input | 1 | Core element read request |
| core_wr_en | input | 1 | Core element write request |
| core_reg | input | 5 | Core register number |
| core_idx | input | 7 | Core element index; values of 64 and above are out of range |
| core_wdata | input | 64 | Core write data |
| core_rdata | output | 64 | Core read data, one cycle after the request |
| core_rvalid | output | 1 | Core read data valid |
| core_err | output | 1 | Core request in the previous cycle had an out-of-range index |
| mem_rd_en | input | 1 | Memory-side element read request |
| mem_wr_en | input | 1 | Memory-side element write request |
| mem_reg | input | 5 | Memory-side register number |
| mem_idx | input | 6 | Memory-side element index |
| mem_wdata | input | 64 | Memory-side write data |
| mem_rdata | output | 64 | Memory-side read data, one cycle after the request |
| mem_rvalid | output | 1 | Memory-side read data valid |
| cfg_vlen | output | 16 | Register length in elements |
| cfg_nregs | output | 16 | Number of registers |

## Verification
Memory-side stores and core element moves can land in the same clock edge. The bench provokes this by driving both request sets at one falling edge.

Three cases are covered:
- Different registers: both stored values are read back afterwards.
- The same element: the stored value must be the memory-side data.
- A core read of an element while the memory side overwrites it: the read must return the old value, and the next read must return the new one.

// File: rtl/vreg_buffer.sv
module vreg_buffer #(
  parameter int ELEM_W = 64,
  parameter int VLEN   = 64,
  parameter int NREGS  = 32,
  parameter int CSR_W  = 16,
  localparam int RW  = $clog2(NREGS),
  localparam int MIW = $clog2(VLEN),
  localparam int IW  = MIW + 1,
  localparam int AW  = RW + MIW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_rd_en,
  input  logic              core_wr_en,
  input  logic [RW-1:0]     core_reg,
  input  logic [IW-1:0]     core_idx,
  input  logic [ELEM_W-1:0] core_wdata,
  output logic [ELEM_W-1:0] core_rdata,
  output logic              core_rvalid,
  output logic              core_err,
  input  logic              mem_rd_en,
  input  logic              mem_wr_en,
  input  logic [RW-1:0]     mem_reg,
  input  logic [MIW-1:0]    mem_idx,
  input  logic [ELEM_W-1:0] mem_wdata,
  output logic [ELEM_W-1:0] mem_rdata,
  output logic              mem_rvalid,
  output logic [CSR_W-1:0]  cfg_vlen,
  output logic [CSR_W-1:0]  cfg_nregs
);

  logic [ELEM_W-1:0] store [NREGS*VLEN];

  logic          core_in_range;
  logic          core_req;
  logic [AW-1:0] core_addr;
  logic [AW-1:0] mem_addr;
  logic          core_wr_ok;

  assign cfg_vlen  = CSR_W'(VLEN);
  assign cfg_nregs = CSR_W'(NREGS);

  assign core_in_range = !core_idx[IW-1];
  assign core_req      = core_rd_en || core_wr_en;
  assign core_addr     = {core_reg, core_idx[MIW-1:0]};
  assign mem_addr      = {mem_reg, mem_idx};
  assign core_wr_ok    = core_wr_en && core_in_range &&
                         !(mem_wr_en && (mem_addr == core_addr));

  always_ff @(posedge clk) begin
    if (mem_wr_en)  store[mem_addr]  <= mem_wdata;
    if (core_wr_ok) store[core_addr] <= core_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      core_rdata  <= '0;
      core_rvalid <= 1'b0;
      core_err    <= 1'b0;
      mem_rdata   <= '0;
      mem_rvalid  <= 1'b0;
    end else begin
      core_rvalid <= core_rd_en && core_in_range;
      core_err    <= core_req && !core_in_range;
      if (core_rd_en && core_in_range) core_rdata <= store[core_addr];
      mem_rvalid  <= mem_rd_en;
      if (mem_rd_en) mem_rdata <= store[mem_addr];
    end
  end

endmodule

module vreg_buffer_chk #(
  parameter int ELEM_W = 64,
  parameter int VLEN   = 64,
  parameter int NREGS  = 32,
  parameter int CSR_W  = 16,
  localparam int RW  = $clog2(NREGS),
  localparam int MIW = $clog2(VLEN),
  localparam int IW  = MIW + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_rd_en,
  input logic              core_wr_en,
  input logic [RW-1:0]     core_reg,
  input logic [IW-1:0]     core_idx,
  input logic [ELEM_W-1:0] core_rdata,
  input logic              core_rvalid,
  input logic              core_err,
  input logic              mem_rd_en,
  input logic              mem_rvalid
);

  p_rd_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    core_rd_en && (core_idx < IW'(VLEN)) |=> core_rvalid && !core_err);

  p_bad_index_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rd_en || core_wr_en) && (core_idx >= IW'(VLEN)) |=> core_err && !core_rvalid);

  p_mem_rd_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> mem_rvalid);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !core_rd_en && !core_wr_en |=> !core_rvalid && !core_err);

  p_mem_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd_en |=> !mem_rvalid);

endmodule

bind vreg_buffer vreg_buffer_chk #(
  .ELEM_W(ELEM_W), .VLEN(VLEN), .NREGS(NREGS), .CSR_W(CSR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .core_rd_en(core_rd_en), .core_wr_en(core_wr_en),
  .core_reg(core_reg), .core_idx(core_idx),
  .core_rdata(core_rdata), .core_rvalid(core_rvalid), .core_err(core_err),
  .mem_rd_en(mem_rd_en), .mem_rvalid(mem_rvalid)
);

// File: tb/tb_vreg_buffer.sv
module tb_vreg_buffer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        core_rd_en, core_wr_en;
  logic [4:0]  core_reg;
  logic [6:0]  core_idx;
  logic [63:0] core_wdata, core_rdata;
  logic        core_rvalid, core_err;
  logic        mem_rd_en, mem_wr_en;
  logic [4:0]  mem_reg;
  logic [5:0]  mem_idx;
  logic [63:0] mem_wdata, mem_rdata;
  logic        mem_rvalid;
  logic [15:0] cfg_vlen, cfg_nregs;

  int errs = 0;
  int checks = 0;

  always #10 clk = ~clk;

  vreg_buffer dut (
    .clk(clk), .rst_n(rst_n),
    .core_rd_en(core_rd_en), .core_wr_en(core_wr_en),
    .core_reg(core_reg), .core_idx(core_idx), .core_wdata(core_wdata),
    .core_rdata(core_rdata), .core_rvalid(core_rvalid), .core_err(core_err),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_reg(mem_reg), .mem_idx(mem_idx), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
    .cfg_vlen(cfg_vlen), .cfg_nregs(cfg_nregs)
  );

  localparam logic [75:0] TBL [8] = '{
    {5'd0,  7'd0,  64'h0123_4567_89AB_CDEF},
    {5'd0,  7'd63, 64'hFFFF_FFFF_FFFF_FFFF},
    {5'd1,  7'd17, 64'h8000_0000_0000_0001},
    {5'd9,  7'd33, 64'hDEAD_BEEF_CAFE_F00D},
    {5'd15, 7'd5,  64'h0000_0000_0000_0000},
    {5'd16, 7'd48, 64'h5A5A_A5A5_5A5A_A5A5},
    {5'd30, 7'd62, 64'h1357_9BDF_2468_ACE0},
    {5'd31, 7'd1,  64'h7FFF_0000_FFFF_0000}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    @(negedge clk);
    core_rd_en = 0; core_wr_en = 0; mem_rd_en = 0; mem_wr_en = 0;
  endtask

  task automatic core_wr(input logic [4:0] r, input logic [6:0] i, input logic [63:0] d);
    core_wr_en = 1; core_reg = r; core_idx = i; core_wdata = d;
    tick(); idle();
  endtask

  task automatic core_rd(input logic [4:0] r, input logic [6:0] i);
    core_rd_en = 1; core_reg = r; core_idx = i;
    tick();
  endtask

  task automatic mem_wr(input logic [4:0] r, input logic [5:0] i, input logic [63:0] d);
    mem_wr_en = 1; mem_reg = r; mem_idx = i; mem_wdata = d;
    tick(); idle();
  endtask

  task automatic mem_rd(input logic [4:0] r, input logic [5:0] i);
    mem_rd_en = 1; mem_reg = r; mem_idx = i;
    tick();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 0;
    core_rd_en = 0; core_wr_en = 0; core_reg = 0; core_idx = 0; core_wdata = 0;
    mem_rd_en = 0; mem_wr_en = 0; mem_reg = 0; mem_idx = 0; mem_wdata = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 core_rvalid", 64'(core_rvalid), 64'd0);
    chk("R10 core_err",    64'(core_err),    64'd0);
    chk("R10 mem_rvalid",  64'(mem_rvalid),  64'd0);
    chk("R10 core_rdata",  core_rdata,       64'd0);
    chk("R10 mem_rdata",   mem_rdata,        64'd0);
    @(negedge clk); rst_n = 1;
    tick();
    chk("R10 core_rvalid after release", 64'(core_rvalid), 64'd0);
    idle();

    chk("R2 cfg_vlen",  64'(cfg_vlen),  64'd64);
    chk("R2 cfg_nregs", 64'(cfg_nregs), 64'd32);

    for (int k = 0; k < 8; k++) begin
      core_wr(TBL[k][75:71], TBL[k][70:64], TBL[k][63:0]);
    end
    for (int k = 0; k < 8; k++) begin
      core_rd(TBL[k][75:71], TBL[k][70:64]);
      chk("R3 core read valid", 64'(core_rvalid), 64'd1);
      chk("R4 R1 core readback", core_rdata, TBL[k][63:0]);
      idle();
      mem_rd(TBL[k][75:71], TBL[k][69:64]);
      chk("R6 mem read valid", 64'(mem_rvalid), 64'd1);
      chk("R4 mem readback", mem_rdata, TBL[k][63:0]);
      idle();
    end

    mem_wr(5'd31, 6'd63, 64'hA5A5_0F0F_F0F0_5A5A);
    core_rd(5'd31, 7'd63);
    chk("R6 R1 mem write seen by core", core_rdata, 64'hA5A5_0F0F_F0F0_5A5A);
    idle();

    mem_wr(5'd4, 6'd0, 64'h1111_2222_3333_4444);
    core_wr_en = 1; core_reg = 5'd3; core_idx = 7'd64; core_wdata = 64'h9999_9999_9999_9999;
    tick();
    chk("R5 write err flag", 64'(core_err), 64'd1);
    idle();
    core_rd(5'd4, 7'd0);
    chk("R5 neighbour untouched", core_rdata, 64'h1111_2222_3333_4444);
    idle();
    core_rd(5'd2, 7'd100);
    chk("R5 read err flag", 64'(core_err), 64'd1);
    chk("R5 no rvalid on bad read", 64'(core_rvalid), 64'd0);
    idle();
    tick();
    chk("R5 err clears", 64'(core_err), 64'd0);
    idle();

    mem_wr_en = 1; mem_reg = 5'd5; mem_idx = 6'd1; mem_wdata = 64'hAAAA_0000_0000_0005;
    core_wr_en = 1; core_reg = 5'd6; core_idx = 7'd1; core_wdata = 64'hBBBB_0000_0000_0006;
    tick(); idle();
    core_rd(5'd5, 7'd1);
    chk("R7 mem side stored", core_rdata, 64'hAAAA_0000_0000_0005);
    idle();
    mem_rd(5'd6, 6'd1);
    chk("R7 core side stored", mem_rdata, 64'hBBBB_0000_0000_0006);
    idle();

    mem_wr_en = 1; mem_reg = 5'd7; mem_idx = 6'd9; mem_wdata = 64'hFEED_0000_0000_0001;
    core_wr_en = 1; core_reg = 5'd7; core_idx = 7'd9; core_wdata = 64'hC0DE_0000_0000_0002;
    tick(); idle();
    core_rd(5'd7, 7'd9);
    chk("R8 mem write wins", core_rdata, 64'hFEED_0000_0000_0001);
    idle();

    core_wr(5'd8, 7'd2, 64'h0000_0000_0000_00AA);
    core_rd_en = 1; core_reg = 5'd8; core_idx = 7'd2;
    mem_wr_en = 1; mem_reg = 5'd8; mem_idx = 6'd2; mem_wdata = 64'h0000_0000_0000_00BB;
    tick();
    chk("R9 old value on collision", core_rdata, 64'h0000_0000_0000_00AA);
    idle();
    core_rd(5'd8, 7'd2);
    chk("R9 new value afterwards", core_rdata, 64'h0000_0000_0000_00BB);
    idle();

    finish_run();
  end

endmodule